// File: doc/BRIEF.md
# Pseudo-Static DRAM Power-State Sequencer

This block decides when a pseudo-static DRAM may be used. A supply-good flag starts a self-initialization period. The period is timed in microseconds from an input tick, and the device is reported ready only when it ends. Chip enable has no effect on this period.

Once the device is ready, a configuration bit can arm deep power-down. With the bit armed, the next rising edge of the active-low chip enable puts the device into the power-down state. To wake the device, chip enable must be held low continuously for a minimum number of microseconds. A low pulse that is too short is ignored, and the next low starts the count again from zero. On wake-up the block pulses a register-reset output for one cycle so the configuration registers go back to their defaults. It then runs the full self-initialization again before ready returns.

Accesses are passed through only while the device is ready. Any access that arrives at another time is dropped.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ready`, `powered_down`, `init_active`, `cfg_reset` and `access_ok` are all 0.
- R2: While `supply_ok` is 0 the block stays idle with all three state flags at 0. A drop of `supply_ok` in any state returns it to idle in the next cycle. At most one of `ready`, `powered_down` and `init_active` is 1 at any time.
- R3: In the cycle after `supply_ok` is first sampled at 1, `init_active` rises. Ready is given in the cycle after the INIT_US-th `us_tick` is sampled during initialization. At that point `init_active` falls and `ready` rises.
- R4: Holding `ce_n` low during initialization neither shortens nor lengthens it.
- R5: When `cfg_dpd_off` is 1, edges on `ce_n` never cause power-down.
- R6: When `cfg_dpd_off` is 0 and the block is ready, a rising edge of `ce_n` (0 in one sampled cycle, 1 in the next) makes `powered_down` 1 in the following cycle.
- R7: Power-down is left only after `ce_n` has been sampled low for EXIT_US consecutive `us_tick`s. A return to high clears the count.
- R8: On leaving power-down, `cfg_reset` is 1 for exactly one cycle, together with the first cycle of `init_active`. A full INIT_US initialization follows before `ready` returns.
- R9: `access_ok` equals `access_req` while `ready` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Core and I/O supplies are at a good level |
| ce_n | input | 1 | Active-low chip enable, synchronous to clk |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_dpd_off | input | 1 | Configuration bit: 0 arms deep power-down, 1 disables it |
| access_req | input | 1 | An access is being attempted |
| ready | output | 1 | Device is usable |
| powered_down | output | 1 | Device is in deep power-down |
| init_active | output | 1 | Self-initialization is running |
| cfg_reset | output | 1 | One-cycle pulse that returns the configuration registers to their defaults |
| access_ok | output | 1 | Access accepted |

## Verification
The assertions assume that `ce_n`, `supply_ok` and `us_tick` are already synchronous to `clk`. They also assume that `us_tick` never lasts more than one cycle, so a rising edge seen at a port is a true edge.

The bench changes every input on the falling clock edge and produces the tick on a fixed 4-cycle cadence, so all of these assumptions hold by construction. Supply loss is applied only once the block is ready, so the idle return is checked from a state the rest of the sequence has already exercised.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_INIT  = 2'd1,
        PS_READY = 2'd2,
        PS_DOWN  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       cfg_reset;
    } pwr_fsm_t;
endpackage

// File: rtl/pwr_ce_monitor.sv
module pwr_ce_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic ce_rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = ce_n;
        ce_rise = ce_n && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/pwr_us_count.sv
module pwr_us_count #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [WIDTH-1:0] target,
    output logic             hit
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        hit = tick && (cnt_q == target - WIDTH'(1));
        if (clear)     cnt_d = '0;
        else if (tick) cnt_d = cnt_q + WIDTH'(1);
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < target || clear);
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int INIT_US = 150,
    parameter int EXIT_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic us_tick,
    input  logic cfg_dpd_off,
    input  logic access_req,
    output logic ready,
    output logic powered_down,
    output logic init_active,
    output logic cfg_reset,
    output logic access_ok
);
    localparam int MAXUS = (INIT_US > EXIT_US) ? INIT_US : EXIT_US;
    localparam int CW    = $clog2(MAXUS + 1);

    pwr_fsm_t    fsm_d, fsm_q;
    logic        ce_rise, cnt_hit, cnt_clear;
    logic [CW-1:0] cnt_target;

    pwr_ce_monitor u_ce (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .ce_rise (ce_rise)
    );

    always_comb begin
        cnt_target = (fsm_q.state == PS_INIT) ? CW'(INIT_US) : CW'(EXIT_US);
        cnt_clear  = !supply_ok || cnt_hit ||
                     (fsm_q.state == PS_OFF) || (fsm_q.state == PS_READY) ||
                     (fsm_q.state == PS_DOWN && ce_n);
    end

    pwr_us_count #(.WIDTH(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .tick   (us_tick),
        .target (cnt_target),
        .hit    (cnt_hit)
    );

    always_comb begin
        fsm_d           = fsm_q;
        fsm_d.cfg_reset = 1'b0;
        unique case (fsm_q.state)
            PS_OFF:   if (supply_ok) fsm_d.state = PS_INIT;
            PS_INIT:  if (cnt_hit) fsm_d.state = PS_READY;
            PS_READY: if (!cfg_dpd_off && ce_rise) fsm_d.state = PS_DOWN;
            PS_DOWN:  if (!ce_n && cnt_hit) begin
                fsm_d.state     = PS_INIT;
                fsm_d.cfg_reset = 1'b1;
            end
            default:  fsm_d.state = PS_OFF;
        endcase
        if (!supply_ok) begin
            fsm_d.state     = PS_OFF;
            fsm_d.cfg_reset = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: PS_OFF, cfg_reset: 1'b0};
        else        fsm_q <= fsm_d;
    end

    always_comb begin
        ready        = (fsm_q.state == PS_READY);
        powered_down = (fsm_q.state == PS_DOWN);
        init_active  = (fsm_q.state == PS_INIT);
        cfg_reset    = fsm_q.cfg_reset;
        access_ok    = access_req && ready;
    end

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, powered_down, init_active}));
    assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !ready && !powered_down && !init_active);
    assert_ready_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(init_active));
    assert_disarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cfg_dpd_off |=> !powered_down);
    assert_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !cfg_dpd_off && ce_rise && supply_ok |=> powered_down);
    assert_exit_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down && ce_n |=> powered_down || !supply_ok);
    assert_cfg_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reset |-> init_active && $past(powered_down));
    assert_cfg_reset_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reset |=> !cfg_reset);
    assert_access_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> ready && access_req);
endmodule

// File: tb/psram_pwr_seq_test.sv
module psram_pwr_seq_test;
    localparam int INIT_US = 150;
    localparam int EXIT_US = 10;

    logic clk = 0, rst_n = 0;
    logic supply_ok = 0, ce_n = 1, us_tick = 0, cfg_dpd_off = 1, access_req = 0;
    logic ready, powered_down, init_active, cfg_reset, access_ok;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string phase = "R1 reset";

    // model state: 0 idle, 1 init, 2 ready, 3 down
    int m_st = 0, m_cnt = 0, m_prev = 1, m_pulse = 0;

    psram_pwr_seq #(.INIT_US(INIT_US), .EXIT_US(EXIT_US)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n),
        .us_tick(us_tick), .cfg_dpd_off(cfg_dpd_off), .access_req(access_req),
        .ready(ready), .powered_down(powered_down), .init_active(init_active),
        .cfg_reset(cfg_reset), .access_ok(access_ok)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        int nst;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_prev = 1; m_pulse = 0;
        end else begin
            nst = m_st; m_pulse = 0;
            if (m_st == 0) begin
                if (supply_ok) nst = 1;
            end else if (m_st == 1) begin
                if (us_tick) begin
                    if (m_cnt == INIT_US - 1) nst = 2; else m_cnt++;
                end
            end else if (m_st == 2) begin
                if (!cfg_dpd_off && m_prev == 0 && ce_n) nst = 3;
            end else begin
                if (ce_n) m_cnt = 0;
                else if (us_tick) begin
                    if (m_cnt == EXIT_US - 1) begin nst = 1; m_pulse = 1; end
                    else m_cnt++;
                end
            end
            if (!supply_ok) begin nst = 0; m_pulse = 0; end
            if (nst != m_st) m_cnt = 0;
            m_prev = ce_n;
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check({phase, " ready"}, ready, m_st == 2);
            check({phase, " powered_down"}, powered_down, m_st == 3);
            check({phase, " init_active"}, init_active, m_st == 1);
            check({phase, " cfg_reset"}, cfg_reset, m_pulse);
            check({phase, " access_ok"}, access_ok, access_req && m_st == 2);
        end
    end

    // 1 us tick every 4 clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            us_tick = 1;
            @(negedge clk);
            us_tick = 0;
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cycles(3);
        check("R1 reset ready", ready, 0);
        check("R1 reset init_active", init_active, 0);
        rst_n = 1;
        phase = "R2 idle without supply";
        wait_cycles(20);
        check("R2 idle init_active", init_active, 0);
        phase = "R3 init timing";
        supply_ok = 1;
        access_req = 1;
        wait_cycles(1);
        check("R3 init starts", init_active, 1);
        phase = "R4 ce low in init";
        ce_n = 0;
        wait_cycles(300);
        check("R4 still initializing", init_active, 1);
        ce_n = 1;
        phase = "R3 init to ready";
        wait_cycles(INIT_US * 4 - 300);
        check("R3 ready after init", ready, 1);
        phase = "R9 access gating";
        wait_cycles(5);
        check("R9 access passes", access_ok, 1);
        access_req = 0;
        wait_cycles(2);
        phase = "R5 disarmed";
        cfg_dpd_off = 1;
        ce_n = 0; wait_cycles(3); ce_n = 1; wait_cycles(3);
        check("R5 no power-down", powered_down, 0);
        phase = "R6 entry";
        cfg_dpd_off = 0;
        ce_n = 0; wait_cycles(3); ce_n = 1; wait_cycles(2);
        check("R6 powered down", powered_down, 1);
        access_req = 1;
        wait_cycles(3);
        check("R9 access blocked in power-down", access_ok, 0);
        phase = "R7 short low ignored";
        ce_n = 0; wait_cycles((EXIT_US - 2) * 4); ce_n = 1; wait_cycles(4);
        check("R7 still down", powered_down, 1);
        ce_n = 0; wait_cycles((EXIT_US - 2) * 4);
        check("R7 count restarted", powered_down, 1);
        phase = "R8 exit and reinit";
        wait_cycles(12);
        check("R8 left power-down", powered_down, 0);
        ce_n = 1;
        wait_cycles(INIT_US * 4 + 8);
        check("R8 ready again", ready, 1);
        phase = "R2 supply loss";
        supply_ok = 0;
        wait_cycles(2);
        check("R2 idle after supply loss", ready, 0);
        supply_ok = 1;
        wait_cycles(20);
        check("R2 reinit after supply return", init_active, 1);
        wait_cycles(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule